// File: doc/BRIEF.md
# Keyed Write-Protection Sequence Detector

This block sits in front of the page write engine of a byte-wide nonvolatile memory and rules on every byte-write that reaches it. It holds a mode bit, open or locked, and watches the written address/data pairs for two keyed command sequences. A three-write key both locks the memory and authorizes the write burst that follows it. A six-write key unlocks it. The per-write verdict is given in the same cycle as the write strobe, so the engine can latch or drop the byte at once.

Each write of a key sequence must follow the previous one within a programmable window of clock cycles. If the window runs out, a half-entered key is forgotten. The same window closes an authorized burst, and a burst also closes once it has delivered a full page. Any write that breaks a key resets the matcher. That write is then judged like any other write, and it may itself start a new key.

Top module: `wp_seq_guard`

## Requirements
- R1: After reset the mode is open (`locked_o` = 0), and a plain write is passed (`wr_pass_o` = 1 in the strobe cycle).
- R2: In open mode every write is passed except the one that completes a key. This includes the leading writes of either key and any write that breaks a key.
- R3: The lock key is three writes in order: 0x1555/0xAA, 0x0AAA/0x55, 0x1555/0xA0. Its third write is never passed, and from the next cycle `locked_o` is 1.
- R4: In locked mode, with no burst authorized, every write is blocked. This includes the writes of a key in progress.
- R5: A completed lock key authorizes the following writes. They pass as long as each one arrives within the window, up to PAGE_BYTES writes. The write after a full page is blocked.
- R6: The unlock key is six writes in order: 0x1555/0xAA, 0x0AAA/0x55, 0x1555/0x80, 0x1555/0xAA, 0x0AAA/0x55, 0x1555/0x20. Its sixth write is never passed, and afterwards `locked_o` is 0 and plain writes pass. In locked mode all six writes are blocked.
- R7: A write that does not match the expected step resets the matcher. If that write equals the first key step, it starts a new key.
- R8: Writes of a key are accepted when each is at most WINDOW_CYC cycles after the previous write. A gap of WINDOW_CYC+1 cycles or more returns the matcher to idle, so the key does not complete.
- R9: Entering the lock key while already locked keeps the mode locked and opens a fresh burst.
- R10: An authorized burst ends when the gap after the previous write exceeds WINDOW_CYC cycles. Later writes are blocked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_valid_i | input | 1 | One byte-write in this cycle |
| wr_addr_i | input | AW | Write address |
| wr_data_i | input | 8 | Write data |
| wr_pass_o | output | 1 | Current write may be committed |
| locked_o | output | 1 | Mode: 1 = locked, 0 = open |

## Verification
The hardest case to reach is the exact edge of the inter-write window in the middle of a key. Here a gap of WINDOW_CYC cycles must still let the key complete, while one more cycle must silently drop it. The only visible effect of the drop is that the later third write changes neither the mode nor the following verdicts. The bench builds every write from a fixed two-cycle strobe plus a counted number of idle cycles, so it can place each gap exactly on either side of the limit. It then probes the result with a plain write afterwards. Breaking a key with a write that is itself the first key step is set up the same way, by chaining writes through the matcher.

// File: rtl/wp_pkg.sv
package wp_pkg;
  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_K1   = 3'd1,
    ST_K2   = 3'd2,
    ST_K3   = 3'd3,
    ST_K4   = 3'd4,
    ST_K5   = 3'd5
  } key_step_e;

  localparam logic [7:0] KEY_D0   = 8'hAA;
  localparam logic [7:0] KEY_D1   = 8'h55;
  localparam logic [7:0] KEY_LOCK = 8'hA0;
  localparam logic [7:0] KEY_ESC  = 8'h80;
  localparam logic [7:0] KEY_OPEN = 8'h20;
endpackage

// File: rtl/wp_gap_timer.sv
module wp_gap_timer #(
  parameter int WINDOW_CYC = 3000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic valid_i,
  output logic expire_o
);
  localparam int TW = $clog2(WINDOW_CYC + 1);
  localparam logic [TW-1:0] LOAD = TW'(WINDOW_CYC);

  logic [TW-1:0] left_q;

  // window closes on the first idle cycle after the last allowed one
  assign expire_o = !valid_i && (left_q == TW'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 left_q <= '0;
    else if (valid_i)            left_q <= LOAD;
    else if (left_q != '0)       left_q <= left_q - TW'(1);
  end

  p_reload_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> left_q == LOAD);
  p_bounded_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    left_q <= LOAD);
endmodule

// File: rtl/wp_key_matcher.sv
module wp_key_matcher
  import wp_pkg::*;
#(
  parameter int AW = 13,
  parameter logic [AW-1:0] ADDR_A = AW'(13'h1555),
  parameter logic [AW-1:0] ADDR_B = AW'(13'h0AAA)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          valid_i,
  input  logic          hold_i,
  input  logic          expire_i,
  input  logic [AW-1:0] addr_i,
  input  logic [7:0]    data_i,
  output logic          lock_o,
  output logic          unlock_o
);
  key_step_e step_q, step_d;
  logic is_a, is_b, first_hit;

  assign is_a      = (addr_i == ADDR_A);
  assign is_b      = (addr_i == ADDR_B);
  assign first_hit = is_a && (data_i == KEY_D0);

  always_comb begin
    step_d   = step_q;
    lock_o   = 1'b0;
    unlock_o = 1'b0;
    if (expire_i) begin
      step_d = ST_IDLE;
    end else if (valid_i && !hold_i) begin
      // default: mismatch restarts, possibly as a new first step
      step_d = first_hit ? ST_K1 : ST_IDLE;
      unique case (step_q)
        ST_IDLE: ;
        ST_K1: if (is_b && data_i == KEY_D1) step_d = ST_K2;
        ST_K2: begin
          if (is_a && data_i == KEY_LOCK) begin
            step_d = ST_IDLE;
            lock_o = 1'b1;
          end else if (is_a && data_i == KEY_ESC) begin
            step_d = ST_K3;
          end
        end
        ST_K3: if (first_hit) step_d = ST_K4;
        ST_K4: if (is_b && data_i == KEY_D1) step_d = ST_K5;
        ST_K5: begin
          if (is_a && data_i == KEY_OPEN) begin
            step_d   = ST_IDLE;
            unlock_o = 1'b1;
          end
        end
        default: step_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) step_q <= ST_IDLE;
    else         step_q <= step_d;
  end

  p_expire_idle_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    expire_i |=> step_q == ST_IDLE);
  p_step_range_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_q <= ST_K5);
  p_hold_freeze_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hold_i && !expire_i) |=> $stable(step_q));
endmodule

// File: rtl/wp_mode_gate.sv
module wp_mode_gate #(
  parameter int PAGE_BYTES = 64
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic valid_i,
  input  logic lock_i,
  input  logic unlock_i,
  input  logic expire_i,
  output logic locked_o,
  output logic burst_o
);
  localparam int CW = $clog2(PAGE_BYTES + 1);
  localparam logic [CW-1:0] LAST = CW'(PAGE_BYTES - 1);

  logic          locked_q, burst_q;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      locked_q <= 1'b0;
      burst_q  <= 1'b0;
      cnt_q    <= '0;
    end else if (lock_i) begin
      locked_q <= 1'b1;
      burst_q  <= 1'b1;
      cnt_q    <= '0;
    end else if (unlock_i) begin
      locked_q <= 1'b0;
      burst_q  <= 1'b0;
      cnt_q    <= '0;
    end else if (expire_i) begin
      burst_q  <= 1'b0;
      cnt_q    <= '0;
    end else if (burst_q && valid_i) begin
      if (cnt_q == LAST) begin
        burst_q <= 1'b0;
        cnt_q   <= '0;
      end else begin
        cnt_q   <= cnt_q + CW'(1);
      end
    end
  end

  assign locked_o = locked_q;
  assign burst_o  = burst_q;

  p_lock_sets_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lock_i |=> locked_q && burst_q);
  p_unlock_clears_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    unlock_i |=> !locked_q && !burst_q);
  p_page_bound_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= LAST);
  p_burst_needs_lock_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    burst_q |-> locked_q);
endmodule

// File: rtl/wp_seq_guard.sv
module wp_seq_guard #(
  parameter int AW         = 13,
  parameter int WINDOW_CYC = 3000,
  parameter int PAGE_BYTES = 64
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_valid_i,
  input  logic [AW-1:0] wr_addr_i,
  input  logic [7:0]    wr_data_i,
  output logic          wr_pass_o,
  output logic          locked_o
);
  logic expire, lock_hit, unlock_hit, burst;

  wp_gap_timer #(.WINDOW_CYC(WINDOW_CYC)) u_timer (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .valid_i  (wr_valid_i),
    .expire_o (expire)
  );

  wp_key_matcher #(.AW(AW)) u_match (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .valid_i  (wr_valid_i),
    .hold_i   (burst),
    .expire_i (expire),
    .addr_i   (wr_addr_i),
    .data_i   (wr_data_i),
    .lock_o   (lock_hit),
    .unlock_o (unlock_hit)
  );

  wp_mode_gate #(.PAGE_BYTES(PAGE_BYTES)) u_gate (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .valid_i  (wr_valid_i),
    .lock_i   (lock_hit),
    .unlock_i (unlock_hit),
    .expire_i (expire),
    .locked_o (locked_o),
    .burst_o  (burst)
  );

  // key-completing writes are command bytes, never data
  assign wr_pass_o = wr_valid_i && !lock_hit && !unlock_hit && (burst || !locked_o);

  p_locked_needs_burst_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_pass_o && locked_o) |-> burst);
  p_key_end_blocked_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lock_hit || unlock_hit) |-> !wr_pass_o);
endmodule

// File: tb/sim_wp_seq_guard.sv
module sim_wp_seq_guard;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 13;
  localparam int WIN = 8;
  localparam int PAGE = 4;
  localparam logic [AW-1:0] KA = 13'h1555;
  localparam logic [AW-1:0] KB = 13'h0AAA;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic vld = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [7:0] data = '0;
  logic pass, locked;
  int n_chk = 0, n_bad = 0;
  logic p;

  always #(CLK_PERIOD/2) clk = ~clk;

  wp_seq_guard #(.AW(AW), .WINDOW_CYC(WIN), .PAGE_BYTES(PAGE)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .wr_valid_i(vld), .wr_addr_i(addr),
    .wr_data_i(data), .wr_pass_o(pass), .locked_o(locked)
  );

  task automatic check(input string tag, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0b expected %0b", tag, act, exp);
    end
  endtask

  task automatic idle(input int k);
    for (int i = 0; i < k; i++) @(negedge clk);
  endtask

  // write gap from previous write = k + 2 cycles
  task automatic wr(input logic [AW-1:0] a, input logic [7:0] d, input int k, output logic pv);
    idle(k);
    @(negedge clk);
    vld = 1'b1; addr = a; data = d;
    #1 pv = pass;
    @(negedge clk);
    vld = 1'b0;
  endtask

  task automatic t_reset();
    check("R1 reset mode", locked, 1'b0);
    wr(13'h0123, 8'h11, 0, p); check("R1 plain pass", p, 1'b1);
  endtask

  task automatic t_lock_and_burst();
    wr(KA, 8'hAA, 0, p); check("R2 key step1 passes", p, 1'b1);
    wr(KB, 8'h55, 0, p); check("R2 key step2 passes", p, 1'b1);
    wr(KA, 8'hA0, 0, p); check("R3 lock byte blocked", p, 1'b0);
    check("R3 locked", locked, 1'b1);
    for (int i = 0; i < PAGE; i++) begin
      wr(13'h0040 + AW'(i), 8'(i), 0, p); check("R5 burst pass", p, 1'b1);
    end
    wr(13'h0050, 8'h77, 0, p); check("R5 past page blocked", p, 1'b0);
    wr(13'h0051, 8'h78, 0, p); check("R4 locked plain blocked", p, 1'b0);
  endtask

  task automatic t_relock_expire();
    idle(WIN + 2);
    wr(KA, 8'hAA, 0, p); check("R4 key step blocked", p, 1'b0);
    wr(KB, 8'h55, 0, p); check("R4 key step blocked", p, 1'b0);
    wr(KA, 8'hA0, 0, p); check("R9 relock byte blocked", p, 1'b0);
    check("R9 still locked", locked, 1'b1);
    wr(13'h0100, 8'h01, 0, p); check("R9 burst reopened", p, 1'b1);
    wr(13'h0101, 8'h02, WIN - 2, p); check("R10 gap at limit passes", p, 1'b1);
    wr(13'h0102, 8'h03, WIN - 1, p); check("R10 gap over limit blocked", p, 1'b0);
  endtask

  task automatic t_key_window();
    idle(WIN + 2);
    wr(KA, 8'hAA, 0, p);
    wr(KB, 8'h55, WIN - 2, p);
    wr(KA, 8'hA0, WIN - 2, p);
    wr(13'h0200, 8'h05, 0, p); check("R8 key at window edge opens burst", p, 1'b1);
    idle(WIN + 2);
    wr(KA, 8'hAA, 0, p);
    wr(KB, 8'h55, 0, p);
    wr(KA, 8'hA0, WIN - 1, p);
    wr(13'h0201, 8'h06, 0, p); check("R8 late key dropped", p, 1'b0);
  endtask

  task automatic t_mismatch();
    idle(WIN + 2);
    wr(KA, 8'hAA, 0, p);
    wr(KB, 8'h55, 0, p);
    wr(KA, 8'h33, 0, p); check("R7 breaking write judged locked", p, 1'b0);
    wr(KA, 8'hA0, 0, p);
    wr(13'h0300, 8'h09, 0, p); check("R7 broken key no burst", p, 1'b0);
    wr(KA, 8'hAA, 0, p);
    wr(KA, 8'hAA, 0, p);
    wr(KB, 8'h55, 0, p);
    wr(KA, 8'hA0, 0, p);
    wr(13'h0301, 8'h0A, 0, p); check("R7 restart on first step", p, 1'b1);
  endtask

  task automatic t_unlock();
    logic [AW-1:0] ua [6] = '{KA, KB, KA, KA, KB, KA};
    logic [7:0]    ud [6] = '{8'hAA, 8'h55, 8'h80, 8'hAA, 8'h55, 8'h20};
    idle(WIN + 2);
    for (int i = 0; i < 6; i++) begin
      wr(ua[i], ud[i], 0, p); check("R6 unlock write blocked when locked", p, 1'b0);
    end
    check("R6 unlocked", locked, 1'b0);
    wr(13'h0400, 8'h44, 0, p); check("R6 plain pass after unlock", p, 1'b1);
    for (int i = 0; i < 6; i++) begin
      wr(ua[i], ud[i], 0, p);
      check("R6 open-mode unlock verdict", p, (i == 5) ? 1'b0 : 1'b1);
    end
    check("R6 stays open", locked, 1'b0);
    wr(KA, 8'hAA, 0, p);
    wr(KB, 8'h12, 0, p); check("R2 breaking write passes open", p, 1'b1);
  endtask

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(1);
    t_reset();
    t_lock_and_burst();
    t_relock_expire();
    t_key_window();
    t_mismatch();
    t_unlock();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule